// File: doc/BRIEF.md
# Remote Terminal Buffer Address and Status Builder

This block sits behind the word receiver of a serial avionics bus remote terminal. When a command word has been accepted, it decodes the direction, sub-address and word count. It also decides whether the command is in error. For every data word of the message, it then supplies the address of that word in a 2048 x 16 backend memory. The memory holds 64 buffers of 32 words. Each of the 30 usable sub-addresses owns one receive buffer and one transmit buffer.

The block keeps a running message-error flag. This flag covers command errors and any word-level errors that the receiver reports during the message. From the flag it forms the status word that the terminal returns on the bus. When the message ends, it produces a transfer status word and the memory address that word goes to. That address lies in the receive areas of sub-addresses 0 and 31, which serve no data traffic. A command addressed to terminal address 31 is a broadcast, and no status word is sent for it.

Top module: `rt_bufmap`

## Requirements
- R1: `mem_addr` equals {T/R bit (command bit 10), sub-address (command bits 9:5), `word_idx`} of the most recently accepted command. Before any command after reset it equals {0, 0, `word_idx`}.
- R2: `tsw_addr` equals {0, 5'd31, sub-address} when the latched command is transmit, and {0, 5'd0, sub-address} when it is receive. Both are locations in receive buffers of sub-addresses 31 and 0.
- R3: `status_word` bits 15:11 always equal `term_addr`, and bits 9:0 are always 0.
- R4: `status_word` bit 10 (message error) is 1 after a command is accepted when any of these holds: `cmd_legal` was 0; the sub-address was 0 or 31; the command was broadcast (bits 15:11 = 31) with the transmit bit set; or `word_err` was 1 in any cycle after acceptance. Otherwise it is 0.
- R5: `bcast` is 1 while the latched command has terminal-address field 31. For such a message, `sw_send` stays 0 at message end.
- R6: `msg_done` in one cycle makes `tsw_valid` 1 in the next cycle, for that cycle only. In that cycle `tsw_word` bit 15 = 1. Bit 14 = 1 only if no command or word error was recorded. Bit 13 = `bus_sel` as sampled with the command.
- R7: When `tsw_valid` is 1, `tsw_word` bit 12 = broadcast, bit 11 = command error, bit 10 = word error, bits 9:5 = 0, and bits 4:0 = the raw word-count field (a count field of 0 is kept as 0, meaning 32 words).
- R8: `sw_send` pulses for one cycle, in the cycle after `msg_done`, for a non-broadcast message.
- R9: While reset is low and in the first cycle after it, `tsw_valid`, `sw_send`, `bcast`, `tsw_word` and status bit 10 are 0.
- R10: When `word_err` and `cmd_valid` are 1 in the same cycle, the word error is discarded. The new command starts with only its own command error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Accept `cmd_word` this cycle |
| cmd_word | input | 16 | Received command word |
| cmd_legal | input | 1 | Legality check result for `cmd_word` |
| term_addr | input | 5 | This terminal's address |
| bus_sel | input | 1 | Bus that carried the command (0 or 1) |
| word_idx | input | 5 | Index of the current data word |
| word_err | input | 1 | Receiver flagged a word error this cycle |
| msg_done | input | 1 | Message ends this cycle |
| mem_addr | output | 11 | Backend address of the current data word |
| tsw_addr | output | 11 | Backend address for the transfer status word |
| status_word | output | 16 | Status word to return on the bus |
| tsw_word | output | 16 | Transfer status word |
| tsw_valid | output | 1 | `tsw_word` is to be written this cycle |
| sw_send | output | 1 | Send the status word this cycle |
| bcast | output | 1 | Latched command is broadcast |

## Verification
A wrongly latched direction or sub-address shows up at once on `mem_addr` and `tsw_addr`. It is visible in the cycle after acceptance, before any data word is moved. A stuck or lost error bit is first visible as status bit 10 in the cycle after the faulty event. It then shows up again in bits 14, 11 and 10 of the transfer status word one cycle after `msg_done`. A mis-held bus or broadcast bit can stay hidden until message end, where it surfaces in `tsw_word` and in a missing or extra `sw_send` pulse.

// File: rtl/rt_bufmap_pkg.sv
package rt_bufmap_pkg;
    localparam int RTA_W    = 5;
    localparam int SA_W     = 5;
    localparam int IDX_W    = 5;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 1 + SA_W + IDX_W;
    localparam logic [RTA_W-1:0] BCAST_RTA = '1;
    localparam logic [SA_W-1:0]  SA_LOW    = '0;
    localparam logic [SA_W-1:0]  SA_HIGH   = '1;

    typedef struct packed {
        logic              tr;
        logic [SA_W-1:0]   sa;
        logic [IDX_W-1:0]  wc;
        logic              bus;
        logic              bc;
        logic              cmd_err;
        logic              word_err;
        logic              tsw_vld;
        logic              sw_send;
        logic [WORD_W-1:0] tsw;
    } rt_state_t;
endpackage

// File: rtl/rt_cmd_check.sv
module rt_cmd_check
    import rt_bufmap_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              cmd_legal,
    output logic              tr,
    output logic [SA_W-1:0]   sa,
    output logic [IDX_W-1:0]  wc,
    output logic              bc,
    output logic              err
);
    logic sa_bad;

    always_comb begin
        tr     = cmd_word[IDX_W+SA_W];
        sa     = cmd_word[IDX_W +: SA_W];
        wc     = cmd_word[IDX_W-1:0];
        bc     = (cmd_word[WORD_W-1 -: RTA_W] == BCAST_RTA);
        sa_bad = (sa == SA_LOW) || (sa == SA_HIGH);
        err    = !cmd_legal || sa_bad || (bc && tr);
    end
endmodule

// File: rtl/rt_addr_gen.sv
module rt_addr_gen
    import rt_bufmap_pkg::*;
(
    input  logic              tr,
    input  logic [SA_W-1:0]   sa,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] tsw_addr
);
    localparam int PAD_W = IDX_W - SA_W;

    always_comb begin
        mem_addr = {tr, sa, idx};
    end

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb tsw_addr = {1'b0, (tr ? SA_HIGH : SA_LOW), {PAD_W{1'b0}}, sa};
        end else begin : g_nopad
            always_comb tsw_addr = {1'b0, (tr ? SA_HIGH : SA_LOW), sa[IDX_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/rt_status_build.sv
module rt_status_build
    import rt_bufmap_pkg::*;
(
    input  logic [RTA_W-1:0]  term_addr,
    input  logic              msg_err,
    input  logic              bus,
    input  logic              bc,
    input  logic              cmd_err,
    input  logic              word_err,
    input  logic [IDX_W-1:0]  wc,
    output logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] tsw_next
);
    localparam int SW_LOW_W  = WORD_W - RTA_W - 1;
    localparam int TSW_GAP_W = WORD_W - 6 - IDX_W;

    always_comb begin
        status_word = {term_addr, msg_err, {SW_LOW_W{1'b0}}};
        tsw_next    = {1'b1, !(cmd_err || word_err), bus, bc, cmd_err, word_err,
                       {TSW_GAP_W{1'b0}}, wc};
    end
endmodule

// File: rtl/rt_bufmap.sv
module rt_bufmap
    import rt_bufmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [WORD_W-1:0]    cmd_word,
    input  logic                 cmd_legal,
    input  logic [RTA_W-1:0]     term_addr,
    input  logic                 bus_sel,
    input  logic [IDX_W-1:0]     word_idx,
    input  logic                 word_err,
    input  logic                 msg_done,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [ADDR_W-1:0]    tsw_addr,
    output logic [WORD_W-1:0]    status_word,
    output logic [WORD_W-1:0]    tsw_word,
    output logic                 tsw_valid,
    output logic                 sw_send,
    output logic                 bcast
);
    rt_state_t st_d, st_q;

    logic              dec_tr, dec_bc, dec_err;
    logic [SA_W-1:0]   dec_sa;
    logic [IDX_W-1:0]  dec_wc;
    logic [WORD_W-1:0] tsw_next;

    rt_cmd_check u_chk (
        .cmd_word (cmd_word),
        .cmd_legal(cmd_legal),
        .tr       (dec_tr),
        .sa       (dec_sa),
        .wc       (dec_wc),
        .bc       (dec_bc),
        .err      (dec_err)
    );

    rt_addr_gen u_addr (
        .tr      (st_q.tr),
        .sa      (st_q.sa),
        .idx     (word_idx),
        .mem_addr(mem_addr),
        .tsw_addr(tsw_addr)
    );

    rt_status_build u_stat (
        .term_addr  (term_addr),
        .msg_err    (st_q.cmd_err || st_q.word_err),
        .bus        (st_q.bus),
        .bc         (st_q.bc),
        .cmd_err    (st_q.cmd_err),
        .word_err   (st_q.word_err || word_err),
        .wc         (st_q.wc),
        .status_word(status_word),
        .tsw_next   (tsw_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tsw_vld = 1'b0;
        st_d.sw_send = 1'b0;
        if (cmd_valid) begin
            st_d.tr       = dec_tr;
            st_d.sa       = dec_sa;
            st_d.wc       = dec_wc;
            st_d.bus      = bus_sel;
            st_d.bc       = dec_bc;
            st_d.cmd_err  = dec_err;
            st_d.word_err = 1'b0;
        end else begin
            if (word_err) st_d.word_err = 1'b1;
            if (msg_done) begin
                st_d.tsw_vld = 1'b1;
                st_d.sw_send = !st_q.bc;
                st_d.tsw     = tsw_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tsw_word  = st_q.tsw_vld ? st_q.tsw : '0;
    assign tsw_valid = st_q.tsw_vld;
    assign sw_send   = st_q.sw_send;
    assign bcast     = st_q.bc;
endmodule

// File: rtl/rt_bufmap_chk.sv
module rt_bufmap_chk
    import rt_bufmap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [WORD_W-1:0] cmd_word,
    input logic              msg_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] status_word,
    input logic [WORD_W-1:0] tsw_word,
    input logic              tsw_valid,
    input logic              sw_send,
    input logic              bcast
);
    AST_ADDR_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> mem_addr[ADDR_W-1:IDX_W] == $past(cmd_word[IDX_W+SA_W:IDX_W])); // R1
    AST_BCAST_TX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[WORD_W-1 -: RTA_W] == BCAST_RTA && cmd_word[IDX_W+SA_W])
        |=> status_word[WORD_W-RTA_W-1]); // R4
    AST_BCAST_NO_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_done && !cmd_valid && bcast) |=> !sw_send); // R5
    AST_TSW_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_done && !cmd_valid) |=> (tsw_valid && tsw_word[WORD_W-1])); // R6
    AST_TSW_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        tsw_valid |-> (tsw_word[WORD_W-2] == !(tsw_word[11] || tsw_word[10]))); // R6
endmodule

bind rt_bufmap rt_bufmap_chk u_chk_bind (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .msg_done   (msg_done),
    .mem_addr   (mem_addr),
    .status_word(status_word),
    .tsw_word   (tsw_word),
    .tsw_valid  (tsw_valid),
    .sw_send    (sw_send),
    .bcast      (bcast)
);

// File: tb/sim_rt_bufmap.sv
module sim_rt_bufmap;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        cmd_legal = 1'b1;
    logic [4:0]  term_addr = 5'd9;
    logic        bus_sel = 1'b0;
    logic [4:0]  word_idx = '0;
    logic        word_err = 1'b0;
    logic        msg_done = 1'b0;
    logic [10:0] mem_addr, tsw_addr;
    logic [15:0] status_word, tsw_word;
    logic        tsw_valid, sw_send, bcast;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_bufmap u0 (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic cmd_error(input logic [15:0] cw, input logic legal);
        return !legal || cw[9:5] == 5'd0 || cw[9:5] == 5'd31 ||
               (cw[15:11] == 5'd31 && cw[10]);
    endfunction

    function automatic logic [15:0] exp_tsw(input logic [15:0] cw, input logic bus,
                                            input logic ce, input logic we);
        return {1'b1, !(ce || we), bus, cw[15:11] == 5'd31, ce, we, 5'd0, cw[4:0]};
    endfunction

    // one message: accept, nwords data words, end
    task automatic run_msg(input logic [15:0] cw, input logic legal, input logic bus,
                           input int nwords, input int err_pct, input bit err_on_cmd);
        logic ce, we, bc;
        ce = cmd_error(cw, legal);
        bc = (cw[15:11] == 5'd31);
        we = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = cw; cmd_legal = legal; bus_sel = bus;
        word_err  = err_on_cmd;
        @(posedge clk); #1;
        cmd_valid = 1'b0; word_err = 1'b0; bus_sel = ~bus;
        chk("R5 bcast", {15'd0, bcast}, {15'd0, bc});
        chk("R4 status err after cmd (R10)", {15'd0, status_word[10]}, {15'd0, ce});
        chk("R2 tsw_addr", {5'd0, tsw_addr}, {5'd0, 1'b0, (cw[10] ? 5'd31 : 5'd0), cw[9:5]});
        for (int i = 0; i < nwords; i++) begin
            @(negedge clk);
            word_idx = 5'(i);
            word_err = ($urandom_range(99) < err_pct);
            #1;
            chk("R1 mem_addr", {5'd0, mem_addr}, {5'd0, cw[10], cw[9:5], 5'(i)});
            if (word_err) we = 1'b1;
            @(posedge clk); #1;
            word_err = 1'b0;
            chk("R4 status err", {15'd0, status_word[10]}, {15'd0, ce || we});
        end
        @(negedge clk);
        term_addr = 5'($urandom_range(30));
        msg_done = 1'b1;
        @(posedge clk); #1;
        msg_done = 1'b0;
        chk("R6 tsw_valid", {15'd0, tsw_valid}, 16'd1);
        chk("R6 R7 tsw_word", tsw_word, exp_tsw(cw, bus, ce, we));
        chk("R8 sw_send", {15'd0, sw_send}, {15'd0, !bc});
        chk("R3 status word", status_word, {term_addr, ce || we, 10'd0});
        @(posedge clk); #1;
        chk("R6 tsw_valid one cycle", {15'd0, tsw_valid}, 16'd0);
        chk("R8 sw_send one cycle", {15'd0, sw_send}, 16'd0);
    endtask

    initial begin
        void'($urandom(32'h1553_0A5E));
        repeat (3) @(posedge clk);
        #1;
        chk("R9 tsw_valid reset", {15'd0, tsw_valid}, 16'd0);
        chk("R9 sw_send reset", {15'd0, sw_send}, 16'd0);
        chk("R9 tsw_word reset", tsw_word, 16'd0);
        chk("R9 status reset", status_word, {5'd9, 11'd0});
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R9 bcast after reset", {15'd0, bcast}, 16'd0);
        chk("R1 mem_addr after reset", {5'd0, mem_addr}, {11'd0});

        // directed corner cases
        run_msg({5'd9, 1'b0, 5'd3, 5'd4},  1'b1, 1'b0, 4, 0, 1'b0);   // legal receive
        run_msg({5'd9, 1'b1, 5'd30, 5'd0}, 1'b1, 1'b1, 3, 0, 1'b0);   // transmit, count 0
        run_msg({5'd31, 1'b1, 5'd7, 5'd2}, 1'b1, 1'b0, 2, 0, 1'b0);   // broadcast transmit
        run_msg({5'd31, 1'b0, 5'd7, 5'd2}, 1'b1, 1'b1, 2, 0, 1'b0);   // broadcast receive
        run_msg({5'd9, 1'b0, 5'd0, 5'd1},  1'b1, 1'b0, 1, 0, 1'b0);   // sa 0
        run_msg({5'd9, 1'b1, 5'd31, 5'd1}, 1'b1, 1'b1, 1, 0, 1'b0);   // sa 31
        run_msg({5'd9, 1'b0, 5'd12, 5'd3}, 1'b0, 1'b0, 3, 0, 1'b0);   // illegal
        run_msg({5'd9, 1'b0, 5'd5, 5'd2},  1'b1, 1'b1, 2, 100, 1'b0); // word errors
        run_msg({5'd9, 1'b1, 5'd6, 5'd2},  1'b1, 1'b0, 2, 0, 1'b1);   // R10 collision

        for (int n = 0; n < 60; n++) begin
            logic [15:0] cw;
            cw = 16'($urandom);
            if ($urandom_range(3) == 0) cw[15:11] = 5'd31;
            run_msg(cw, ($urandom_range(9) != 0), 1'($urandom), $urandom_range(1, 6), 15, 1'b0);
        end
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule